// File: doc/BRIEF.md
# Serial Peripheral Controller Register Bank

This block is the software-visible register bank of a serial peripheral controller. A simple 32-bit bus (address, read strobe, write strobe, write data, read data) reaches fourteen word registers: control, transfer length, two configuration words, interrupt enable, status, flag clear, transmit data, receive data, CRC polynomial, transmit CRC, receive CRC, underrun data and audio configuration. Every register has a fixed reset value. A per-register mask decides which bits a bus write may change.

Status is never written directly. Software clears status flags by writing ones to a separate flag-clear location. Each write to the transmit data location counts the 16-bit remaining-length field down by one. When that field is zero after the step, the end-of-transfer flag in the status word is set. An interrupt line combines the low twelve status flags with their enable bits. The shift engine, the CRC logic and interrupt routing are separate blocks.

Top module: `spi_regbank`

## Requirements
- R1: After reset, reads return 0x0007_0007 at offset 0x08, 0x0000_1002 at offset 0x14 (status) and 0x0000_0107 at offset 0x40. Every other mapped offset reads 0.
- R2: A read strobe captures the addressed register into `rdata` at the next clock edge, so the data is visible in the following cycle. `rdata` holds its value while the read strobe is low.
- R3: A write updates only the bits set in the register's mask, at the next clock edge. The masks are: offset 0x00 uses 0x0001_FF01, 0x04 uses 0xFFFF_FFFF, 0x08 uses 0x705F_DFFF, 0x0C uses 0xF7FE_80FF and 0x10 uses 0x0000_0FFF.
- R4: Writes to offsets 0x30, 0x40, 0x44, 0x48, 0x4C and 0x50 leave those registers at their reset values.
- R5: A write to the status offset 0x14 changes no status bit.
- R6: A write to offset 0x18 clears each status bit in positions 11 to 3 whose write-data bit is 1. Status bits outside 11..3 are untouched. A read of 0x18 returns 0.
- R7: A write to offset 0x20 decrements the register at offset 0x04 by one when its bits 15..0 are nonzero. Otherwise that register is left unchanged.
- R8: After a write to 0x20, if bits 15..0 of offset 0x04 are zero, status bit 3 (end of transfer) is set. This holds even if the field was already zero before the write.
- R9: A read of offset 0x20, or of any unmapped offset, returns 0.
- R10: `irq` is high exactly when some status bit i in 11..0 and bit i of the interrupt enable register (offset 0x10) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Byte offset of the register accessed |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq | output | 1 | Enabled status flags combined |

## Verification
The countdown is driven from lengths of one, two and zero. It is also driven with a length whose low half is zero while its upper half is not. These cases separate a missed decrement, a borrow into the upper half, and an end-of-transfer flag that depends on the old count instead of the new one. Flag-clear writes use all-ones data and single bits, which shows whether the clear reaches past bits 11..3. Random writes with all-ones and random data to every offset, including unmapped and read-only ones, check each mask bit-for-bit. Reads after each random operation and an `irq` check after every operation catch a wrong enable pairing.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int N_REG    = 14;
    localparam int CNT_W    = 16;
    localparam int IRQ_W    = 12;
    localparam int EOT_BIT  = 3;
    localparam int IDX_W    = $clog2(N_REG + 1);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] offs_t;

    localparam word_t FLAG_CLR_MASK = 32'h0000_0FF8;

    typedef enum logic [IDX_W-1:0] {
        IDX_CTRL  = 4'd0,
        IDX_XSIZE = 4'd1,
        IDX_CFGA  = 4'd2,
        IDX_CFGB  = 4'd3,
        IDX_IEN   = 4'd4,
        IDX_STAT  = 4'd5,
        IDX_FCLR  = 4'd6,
        IDX_TXD   = 4'd7,
        IDX_RXD   = 4'd8,
        IDX_POLY  = 4'd9,
        IDX_TXCRC = 4'd10,
        IDX_RXCRC = 4'd11,
        IDX_UNDR  = 4'd12,
        IDX_AUD   = 4'd13,
        IDX_NONE  = 4'd14
    } reg_idx_e;

    typedef enum logic [1:0] {
        KIND_RW,
        KIND_CONST,
        KIND_EXT
    } reg_kind_e;

    typedef struct packed {
        logic     hit;
        reg_idx_e idx;
    } dec_t;

    typedef struct packed {
        logic wr_xsize;
        logic wr_txd;
        logic wr_fclr;
    } xfer_cmd_t;

    function automatic offs_t reg_offset(input reg_idx_e i);
        case (i)
            IDX_CTRL:  return 8'h00;
            IDX_XSIZE: return 8'h04;
            IDX_CFGA:  return 8'h08;
            IDX_CFGB:  return 8'h0C;
            IDX_IEN:   return 8'h10;
            IDX_STAT:  return 8'h14;
            IDX_FCLR:  return 8'h18;
            IDX_TXD:   return 8'h20;
            IDX_RXD:   return 8'h30;
            IDX_POLY:  return 8'h40;
            IDX_TXCRC: return 8'h44;
            IDX_RXCRC: return 8'h48;
            IDX_UNDR:  return 8'h4C;
            IDX_AUD:   return 8'h50;
            default:   return 8'hFF;
        endcase
    endfunction

    function automatic word_t reg_reset(input reg_idx_e i);
        case (i)
            IDX_CFGA: return 32'h0007_0007;
            IDX_STAT: return 32'h0000_1002;
            IDX_POLY: return 32'h0000_0107;
            default:  return '0;
        endcase
    endfunction

    function automatic word_t reg_mask(input reg_idx_e i);
        case (i)
            IDX_CTRL:  return 32'h0001_FF01;
            IDX_XSIZE: return 32'hFFFF_FFFF;
            IDX_CFGA:  return 32'h705F_DFFF;
            IDX_CFGB:  return 32'hF7FE_80FF;
            IDX_IEN:   return 32'h0000_0FFF;
            default:   return '0;
        endcase
    endfunction

    function automatic reg_kind_e reg_kind(input reg_idx_e i);
        case (i)
            IDX_CTRL, IDX_CFGA, IDX_CFGB, IDX_IEN: return KIND_RW;
            IDX_XSIZE, IDX_STAT:                   return KIND_EXT;
            default:                               return KIND_CONST;
        endcase
    endfunction

endpackage

// File: rtl/spi_regbank_decode.sv
module spi_regbank_decode
    import spi_regbank_pkg::*;
(
    input  offs_t addr,
    output dec_t  dec
);
    always_comb begin
        dec.hit = 1'b0;
        dec.idx = IDX_NONE;
        for (int i = 0; i < N_REG; i++) begin
            if (addr == reg_offset(reg_idx_e'(i))) begin
                dec.hit = 1'b1;
                dec.idx = reg_idx_e'(i);
            end
        end
    end
endmodule

// File: rtl/spi_regbank_store.sv
module spi_regbank_store
    import spi_regbank_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  reg_idx_e                      idx,
    input  word_t                         wdata,
    output logic [N_REG-1:0][DATA_W-1:0]  val
);
    for (genvar g = 0; g < N_REG; g++) begin : g_reg
        localparam reg_idx_e  IDX  = reg_idx_e'(g);
        localparam reg_kind_e KIND = reg_kind(IDX);
        localparam word_t     MASK = reg_mask(IDX);
        localparam word_t     RSTV = reg_reset(IDX);
        if (KIND == KIND_RW) begin : g_rw
            word_t q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= RSTV;
                end else if (we && idx == IDX) begin
                    q <= (q & ~MASK) | (wdata & MASK);
                end
            end
            assign val[g] = q;
        end else if (KIND == KIND_CONST) begin : g_const
            assign val[g] = RSTV;
        end else begin : g_ext
            assign val[g] = '0;
        end
    end
endmodule

// File: rtl/spi_regbank_xfer.sv
module spi_regbank_xfer
    import spi_regbank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  xfer_cmd_t cmd,
    input  word_t     wdata,
    output word_t     xsize,
    output word_t     stat
);
    word_t xsize_q, stat_q;
    word_t xsize_dec, stat_nxt;
    logic  cnt_nz, eot_set;

    always_comb begin
        cnt_nz    = |xsize_q[CNT_W-1:0];
        xsize_dec = cnt_nz ? xsize_q - 1'b1 : xsize_q;
        eot_set   = cmd.wr_txd && (xsize_dec[CNT_W-1:0] == '0);
        stat_nxt  = stat_q;
        if (cmd.wr_fclr) begin
            stat_nxt = stat_nxt & ~(wdata & FLAG_CLR_MASK);
        end
        if (eot_set) begin
            stat_nxt[EOT_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xsize_q <= reg_reset(IDX_XSIZE);
            stat_q  <= reg_reset(IDX_STAT);
        end else begin
            if (cmd.wr_xsize) begin
                xsize_q <= (xsize_q & ~reg_mask(IDX_XSIZE)) | (wdata & reg_mask(IDX_XSIZE));
            end else if (cmd.wr_txd) begin
                xsize_q <= xsize_dec;
            end
            stat_q <= stat_nxt;
        end
    end

    assign xsize = xsize_q;
    assign stat  = stat_q;
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
    import spi_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    dec_t                         dec;
    logic [N_REG-1:0][DATA_W-1:0] store_val;
    xfer_cmd_t                    cmd;
    word_t                        xsize_q, stat_q, ien_val, rd_val, rdata_q;
    logic                         wr_hit;

    spi_regbank_decode u_dec (
        .addr (addr),
        .dec  (dec)
    );

    assign wr_hit       = wr_en && dec.hit;
    assign cmd.wr_xsize = wr_hit && dec.idx == IDX_XSIZE;
    assign cmd.wr_txd   = wr_hit && dec.idx == IDX_TXD;
    assign cmd.wr_fclr  = wr_hit && dec.idx == IDX_FCLR;

    spi_regbank_store u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_hit),
        .idx   (dec.idx),
        .wdata (wdata),
        .val   (store_val)
    );

    spi_regbank_xfer u_xfer (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .wdata (wdata),
        .xsize (xsize_q),
        .stat  (stat_q)
    );

    assign ien_val = store_val[IDX_IEN];

    always_comb begin
        if (!dec.hit) begin
            rd_val = '0;
        end else begin
            case (dec.idx)
                IDX_XSIZE: rd_val = xsize_q;
                IDX_STAT:  rd_val = stat_q;
                default:   rd_val = store_val[dec.idx];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= rd_val;
        end
    end

    assign rdata = rdata_q;
    assign irq   = |(stat_q[IRQ_W-1:0] & ien_val[IRQ_W-1:0]);
endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk
    import spi_regbank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input logic [DATA_W-1:0] xsize,
    input logic [DATA_W-1:0] stat,
    input logic [DATA_W-1:0] ien
);
    localparam offs_t OFF_STAT = reg_offset(IDX_STAT);
    localparam offs_t OFF_FCLR = reg_offset(IDX_FCLR);
    localparam offs_t OFF_TXD  = reg_offset(IDX_TXD);

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata)); // R2

    AST_STAT_NO_DIRECT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_STAT) |=> $stable(stat)); // R5

    AST_FCLR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_FCLR) |=> ((stat & $past(wdata) & FLAG_CLR_MASK) == '0)); // R6

    AST_OUTER_FLAGS_KEPT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($stable(stat[2:0]) && $stable(stat[DATA_W-1:12]))); // R6

    AST_TXD_DECR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_TXD && xsize[CNT_W-1:0] != '0) |=> (xsize == $past(xsize) - 1'b1)); // R7

    AST_EOT_SET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_TXD) |=> (xsize[CNT_W-1:0] != '0 || stat[EOT_BIT])); // R8

    AST_RD_TXD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == OFF_TXD) |=> (rdata == '0)); // R9

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ien[IRQ_W-1:0] == '0) |-> !irq); // R10
endmodule

bind spi_regbank spi_regbank_chk i_chk (
    .clk   (clk),
    .rst   (rst),
    .addr  (addr),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq),
    .xsize (xsize_q),
    .stat  (stat_q),
    .ien   (ien_val)
);

// File: tb/test_spi_regbank.sv
`timescale 1ns/1ps
module test_spi_regbank;
    localparam time TCK = 4ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] m_ctrl, m_xsize, m_cfga, m_cfgb, m_ien, m_stat;

    always #(TCK/2) clk = ~clk;

    spi_regbank i_spi_regbank (
        .clk   (clk),
        .rst   (rst),
        .addr  (addr),
        .rd_en (rd_en),
        .wr_en (wr_en),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h00: return m_ctrl;
            8'h04: return m_xsize;
            8'h08: return m_cfga;
            8'h0C: return m_cfgb;
            8'h10: return m_ien;
            8'h14: return m_stat;
            8'h40: return 32'h0000_0107;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_irq();
        return |(m_stat[11:0] & m_ien[11:0]);
    endfunction

    task automatic mdl_reset();
        m_ctrl = 0; m_xsize = 0; m_cfga = 32'h0007_0007;
        m_cfgb = 0; m_ien = 0; m_stat = 32'h0000_1002;
    endtask

    task automatic mdl_wr(input logic [7:0] a, input logic [31:0] d);
        case (a)
            8'h00: m_ctrl  = (m_ctrl & ~32'h0001_FF01) | (d & 32'h0001_FF01);
            8'h04: m_xsize = d;
            8'h08: m_cfga  = (m_cfga & ~32'h705F_DFFF) | (d & 32'h705F_DFFF);
            8'h0C: m_cfgb  = (m_cfgb & ~32'hF7FE_80FF) | (d & 32'hF7FE_80FF);
            8'h10: m_ien   = (m_ien & ~32'h0000_0FFF) | (d & 32'h0000_0FFF);
            8'h18: m_stat  = m_stat & ~(d & 32'h0000_0FF8);
            8'h20: begin
                if (m_xsize[15:0] != 0) m_xsize = m_xsize - 1;
                if (m_xsize[15:0] == 0) m_stat[3] = 1'b1;
            end
            default: ;
        endcase
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        mdl_wr(a, d);
        check("R10 irq", {31'b0, irq}, {31'b0, exp_irq()});
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, rdata, exp_rd(a));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(TCK * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    localparam logic [7:0] OFFS [15] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18,
                                         8'h20, 8'h30, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h50, 8'h24};

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20240613));
        mdl_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values at every offset
        for (int i = 0; i < 15; i++) rd(OFFS[i], "R1 reset value");
        check("R1 irq after reset", {31'b0, irq}, 32'b0);

        // R2: read data holds while the read strobe is low
        rd(8'h08, "R2 read cfg");
        held = rdata;
        @(negedge clk); @(negedge clk);
        check("R2 rdata hold", rdata, held);

        // R3: masks with all ones
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, "R3 ctrl mask");
        wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, "R3 cfgb mask");
        wr(8'h08, 32'h0);         rd(8'h08, "R3 cfga clear");

        // R4: constant registers
        wr(8'h40, 32'h0);         rd(8'h40, "R4 poly kept");
        wr(8'h30, 32'hFFFF_FFFF); rd(8'h30, "R4 rxd kept");

        // R5: direct status write ignored
        wr(8'h14, 32'h0);         rd(8'h14, "R5 status kept");

        // R7, R8: countdown from two
        wr(8'h04, 32'h0000_0002);
        wr(8'h20, 32'h0); rd(8'h04, "R7 decrement to 1"); rd(8'h14, "R8 no eot yet");
        wr(8'h20, 32'h0); rd(8'h04, "R7 decrement to 0"); rd(8'h14, "R8 eot set");

        // R6: flag clear with all ones leaves bits 1 and 12
        wr(8'h18, 32'hFFFF_FFFF); rd(8'h14, "R6 clear range"); rd(8'h18, "R6 fclr reads 0");

        // R8: write at zero length still raises end of transfer
        wr(8'h20, 32'h0); rd(8'h04, "R7 stays zero"); rd(8'h14, "R8 eot at zero");

        // R7: low half zero, upper half kept
        wr(8'h04, 32'h0005_0000);
        wr(8'h20, 32'h0); rd(8'h04, "R7 no borrow");

        // R9: write-only and unmapped reads
        rd(8'h20, "R9 txd reads 0");
        rd(8'h24, "R9 unmapped 0");

        // R10: enable the status bit 1 flag
        wr(8'h10, 32'h0000_0002);
        check("R10 irq on bit1", {31'b0, irq}, 32'h1);
        wr(8'h10, 32'h0);

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [7:0]  a;
            logic [31:0] d;
            a = OFFS[$urandom_range(0, 14)];
            case ($urandom_range(0, 2))
                0:       d = $urandom_range(0, 3);
                1:       d = 32'hFFFF_FFFF;
                default: d = $urandom;
            endcase
            if ($urandom_range(0, 1) == 0) wr(a, d);
            rd(OFFS[$urandom_range(0, 14)], "R3 random read");
        end

        finish_run();
    end
endmodule